// File: doc/BRIEF.md
# Shared Interrupt Flag Controller

This block gathers three interrupt event sources (a periodic time update, a fixed-cycle timer and an alarm match) into sticky status flags and one shared active-low interrupt line. Each source delivers a one-cycle event strobe. The event always sets that source's flag. When the source's enable bit is on, the event also raises a request that pulls the shared line low. The line is modelled by `irq_drive`: high means the open-drain output sinks current, and low means it is released to high impedance.

The three sources release their requests by different rules. The update and timer requests are pulses that count a fixed number of 32.768 kHz ticks, supplied as a clock enable, and then drop on their own. The timer pulse is short when the timer runs from its 4096 Hz source and long for every slower source. The alarm request stays until software clears the alarm flag. Clearing an update or timer flag leaves a running pulse in place. Clearing any enable bit drops that source's request at once.

Host software reads the flag byte, clears flags by writing zeros to it, and writes the three enable bits. The block contains neither the event generators nor the serial host bus.

Top module: `irq_share_ctl`

## Requirements
- R1: After a synchronous reset, `flag_rdata` reads 0x00, `irq_drive` is 0 and all three enable bits are 0, so an event that follows reset does not drive the line.
- R2: An event strobe sets its flag in the next cycle: update at `flag_rdata` bit 5, timer at bit 4, alarm at bit 3. Bits 7, 6 and 2..0 always read 0.
- R3: During a flag write, a 0 in bit 5, 4 or 3 of `flag_wdata` clears that flag and a 1 leaves it unchanged. An event in the same cycle as a clear of its flag leaves the flag set.
- R4: An event whose enable bit is 0 sets its flag but does not drive the line, and a later enable write does not turn that earlier event into a request.
- R5: `irq_drive` is 1 exactly when at least one source holds a request. An enable write on its own never starts a request.
- R6: The update request lasts `UPD_TICKS` tick enables after its event. A new update event during the pulse restarts the full count.
- R7: The timer request lasts `TMR_FAST_TICKS` (4) tick enables when `tmr_src` is 0 (4096 Hz source) at the event, and `TMR_SLOW_TICKS` (256) when `tmr_src` is 1, 2 or 3.
- R8: The alarm request never ends with ticks. It holds until bit 3 is written as 0 in a flag write or its enable is cleared.
- R9: Clearing the update or timer flag while its pulse runs does not shorten the pulse.
- R10: An enable write with bit 2 (update), bit 1 (timer) or bit 0 (alarm) of `en_wdata` at 0 drops that source's request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz tick enable, one cycle wide |
| upd_evt | input | 1 | Time update event strobe |
| tmr_evt | input | 1 | Fixed-cycle timer event strobe |
| alm_evt | input | 1 | Alarm match event strobe |
| tmr_src | input | 2 | Timer source code: 0 = 4096 Hz, 1 = 64 Hz, 2 = second, 3 = minute |
| flag_wr | input | 1 | Host write to the flag byte |
| flag_wdata | input | 8 | Flag write data; zeros at bits 5/4/3 clear flags |
| en_wr | input | 1 | Host write to the enable bits |
| en_wdata | input | 3 | Enable data: bit 2 update, bit 1 timer, bit 0 alarm |
| flag_rdata | output | 8 | Flag readback: bit 5 update, bit 4 timer, bit 3 alarm |
| irq_drive | output | 1 | 1 while the shared open-drain line is pulled low |

## Verification
The hardest situation to reach is a running update or timer pulse whose flag has already been cleared, or which a fresh event restarts partway through. Both depend on where a counter stands at the moment of the host action. The bench holds `tick_en` low while it walks the vector table, so a request started there stays frozen while the flag is cleared and the enables are rewritten around it. The directed tests then release the ticks one cycle at a time and count edges until the line lets go. They also restart a pulse that is five ticks in and count the whole length again.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

    // Flag positions in the host-visible byte
    localparam int UF_POS = 5;
    localparam int TF_POS = 4;
    localparam int AF_POS = 3;

    // Source indices inside every per-source vector
    localparam int SRC_ALM = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_UPD = 2;
    localparam int N_SRC   = 3;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        TSRC_FAST = 2'd0,
        TSRC_SLOW = 2'd1,
        TSRC_SEC  = 2'd2,
        TSRC_MIN  = 2'd3
    } tmr_src_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pull the three flag bits out of a register byte
    function automatic src_vec_t pick_flags(logic [7:0] b);
        src_vec_t f;
        f[SRC_UPD] = b[UF_POS];
        f[SRC_TMR] = b[TF_POS];
        f[SRC_ALM] = b[AF_POS];
        return f;
    endfunction

    // Place the three flags into a register byte, other bits zero
    function automatic logic [7:0] place_flags(src_vec_t f);
        logic [7:0] b;
        b = '0;
        b[UF_POS] = f[SRC_UPD];
        b[TF_POS] = f[SRC_TMR];
        b[AF_POS] = f[SRC_ALM];
        return b;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_share_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  logic     wr,
    input  src_vec_t wkeep,
    output src_vec_t flags,
    output logic     alm_clr
);
    src_vec_t clr_hit;

    // A write clears where the data bit is 0; an event in the same cycle wins
    always_comb begin
        clr_hit = wr ? ~wkeep : '0;
        alm_clr = clr_hit[SRC_ALM];
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr_hit) | evt;
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_share_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  src_vec_t wdata,
    output src_vec_t en_q,
    output src_vec_t en_eff
);
    // Value in force during this cycle, including a write arriving now
    assign en_eff = wr ? wdata : en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else
            en_q <= en_eff;
    end
endmodule

// File: rtl/irq_pulse_src.sv
module irq_pulse_src #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             fire,
    input  logic             drop,
    input  logic [CNT_W-1:0] len,
    output logic             active
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (fire)
            remain <= len;
        else if (drop)
            remain <= '0;
        else if (tick_en && remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
endmodule

// File: rtl/irq_hold_src.sv
module irq_hold_src (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    input  logic drop,
    output logic active
);
    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else if (fire)
            active <= 1'b1;
        else if (clr || drop)
            active <= 1'b0;
    end
endmodule

// File: rtl/irq_share_ctl.sv
module irq_share_ctl
    import irq_share_pkg::*;
#(
    parameter int unsigned UPD_TICKS      = 256,
    parameter int unsigned TMR_FAST_TICKS = 4,
    parameter int unsigned TMR_SLOW_TICKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       upd_evt,
    input  logic       tmr_evt,
    input  logic       alm_evt,
    input  logic [1:0] tmr_src,
    input  logic       flag_wr,
    input  logic [7:0] flag_wdata,
    input  logic       en_wr,
    input  logic [2:0] en_wdata,
    output logic [7:0] flag_rdata,
    output logic       irq_drive
);
    localparam int unsigned MAX_TICKS = max2(UPD_TICKS, max2(TMR_FAST_TICKS, TMR_SLOW_TICKS));
    localparam int          CNT_W     = $clog2(MAX_TICKS + 1);

    src_vec_t evt_vec, wkeep, flags, en_q, en_eff, fire, req_vec;
    logic     alm_clr;
    logic     wdata_unused;
    tmr_src_e src_sel;

    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = upd_evt;
        evt_vec[SRC_TMR] = tmr_evt;
        evt_vec[SRC_ALM] = alm_evt;
    end

    assign wkeep        = pick_flags(flag_wdata);
    assign wdata_unused = ^{flag_wdata[7:6], flag_wdata[2:0], en_q};
    assign src_sel      = tmr_src_e'(tmr_src);

    irq_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_vec),
        .wr      (flag_wr),
        .wkeep   (wkeep),
        .flags   (flags),
        .alm_clr (alm_clr)
    );

    irq_enable_reg u_en (
        .clk    (clk),
        .rst    (rst),
        .wr     (en_wr),
        .wdata  (en_wdata),
        .en_q   (en_q),
        .en_eff (en_eff)
    );

    assign fire = evt_vec & en_eff;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g == SRC_ALM) begin : g_hold
            irq_hold_src u_hold (
                .clk    (clk),
                .rst    (rst),
                .fire   (fire[g]),
                .clr    (alm_clr),
                .drop   (~en_eff[g]),
                .active (req_vec[g])
            );
        end else begin : g_pulse
            logic [CNT_W-1:0] len_g;
            if (g == SRC_UPD) begin : g_len_upd
                assign len_g = CNT_W'(UPD_TICKS);
            end else begin : g_len_tmr
                assign len_g = (src_sel == TSRC_FAST) ? CNT_W'(TMR_FAST_TICKS)
                                                      : CNT_W'(TMR_SLOW_TICKS);
            end
            irq_pulse_src #(.CNT_W(CNT_W)) u_pulse (
                .clk     (clk),
                .rst     (rst),
                .tick_en (tick_en),
                .fire    (fire[g]),
                .drop    (~en_eff[g]),
                .len     (len_g),
                .active  (req_vec[g])
            );
        end
    end

    assign irq_drive  = |req_vec;
    assign flag_rdata = place_flags(flags);
endmodule

// File: rtl/irq_share_chk.sv
module irq_share_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] evt_v,
    input logic       flag_wr,
    input logic [2:0] wdata_f,
    input logic       en_wr,
    input logic [2:0] en_wdata,
    input logic [2:0] flags_f,
    input logic       irq_drive,
    input logic [2:0] req_vec
);
    // R2: every strobed source has its flag set one cycle later
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
        (evt_v != 3'b000) |=> ((flags_f & $past(evt_v)) == $past(evt_v)));

    // R3: writing 1 over a set flag keeps it set
    a_r3_one_keeps: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flags_f & $past(flags_f & wdata_f)) == $past(flags_f & wdata_f)));

    // R5: the line only starts being driven after some event strobe
    a_r5_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_drive) |-> $past(evt_v != 3'b000));

    // R8: the alarm request persists unless its flag or enable is cleared
    a_r8_alarm_holds: assert property (@(posedge clk) disable iff (rst)
        (req_vec[0] && !(flag_wr && !wdata_f[0]) && !(en_wr && !en_wdata[0])) |=> req_vec[0]);

    // R10: a cleared enable leaves no request for that source
    a_r10_enable_drop: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> ((req_vec & ~$past(en_wdata)) == 3'b000));
endmodule

bind irq_share_ctl irq_share_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_v     ({upd_evt, tmr_evt, alm_evt}),
    .flag_wr   (flag_wr),
    .wdata_f   (flag_wdata[5:3]),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .flags_f   (flag_rdata[5:3]),
    .irq_drive (irq_drive),
    .req_vec   (req_vec)
);

// File: tb/irq_share_ctl_test.sv
module irq_share_ctl_test;
    localparam int UPD_T = 8;
    localparam int NV    = 15;

    // Row: evt{u,t,a} | fwr | fdat{u,t,a} | ewr | edat{u,t,a} | exp flags{u,t,a} | exp irq
    localparam logic [14:0] VT [NV] = '{
        15'b100_0_000_0_000_100_0,  // 0  R4 event with enable off
        15'b000_1_111_0_000_100_0,  // 1  R3 ones change nothing
        15'b000_1_011_0_000_000_0,  // 2  R3 zero clears update flag
        15'b000_0_000_1_111_000_0,  // 3  R5 enable alone does not drive
        15'b010_0_000_0_000_010_1,  // 4  R2 timer event drives
        15'b000_1_101_0_000_000_1,  // 5  R9 clear flag keeps pulse
        15'b000_0_000_1_101_000_0,  // 6  R10 clear timer enable
        15'b001_0_000_0_000_001_1,  // 7  R8 alarm raises
        15'b000_0_000_1_111_001_1,  // 8  R8 alarm still held
        15'b000_1_111_0_000_001_1,  // 9  R3 ones keep alarm flag
        15'b001_1_110_0_000_001_1,  // 10 R3 event beats same-cycle clear
        15'b000_1_110_0_000_000_0,  // 11 R8 alarm released by clear
        15'b111_0_000_0_000_111_1,  // 12 R2 all three events
        15'b000_1_000_0_000_000_1,  // 13 R9 pulses survive flag clear
        15'b000_0_000_1_000_000_0   // 14 R10 all enables cleared
    };

    logic       clk = 1'b0;
    logic       rst, tick_en, upd_evt, tmr_evt, alm_evt, flag_wr, en_wr;
    logic [1:0] tmr_src;
    logic [7:0] flag_wdata;
    logic [2:0] en_wdata;
    logic [7:0] flag_rdata;
    logic       irq_drive;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    irq_share_ctl #(.UPD_TICKS(UPD_T), .TMR_FAST_TICKS(4), .TMR_SLOW_TICKS(256)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .upd_evt(upd_evt), .tmr_evt(tmr_evt), .alm_evt(alm_evt),
        .tmr_src(tmr_src), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .flag_rdata(flag_rdata), .irq_drive(irq_drive)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic string row_tag(int i);
        case (i)
            0:              return "R4";
            1, 2, 9, 10:    return "R3";
            3:              return "R5";
            4, 12:          return "R2";
            5, 13:          return "R9";
            6, 14:          return "R10";
            default:        return "R8";
        endcase
    endfunction

    task automatic idle();
        upd_evt = 0; tmr_evt = 0; alm_evt = 0;
        flag_wr = 0; en_wr = 0;
    endtask

    task automatic write_en(input logic [2:0] v);
        en_wr = 1; en_wdata = v;
        @(negedge clk);
        idle();
    endtask

    task automatic write_flags(input logic [7:0] v);
        flag_wr = 1; flag_wdata = v;
        @(negedge clk);
        idle();
    endtask

    // Run ticks every cycle and count edges until the line is released
    task automatic measure(output int n);
        n = 0;
        tick_en = 1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            n++;
            if (!irq_drive) break;
        end
        tick_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1; tick_en = 0; tmr_src = 2'd0; flag_wdata = 8'h00; en_wdata = 3'b000;
        idle();
        repeat (3) @(negedge clk);
        check("R1 reset flags", flag_rdata, 8'h00);
        check("R1 reset irq", irq_drive, 0);
        rst = 0;
        @(negedge clk);

        // Vector table, ticks held off so pulses stay frozen
        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VT[i];
            {upd_evt, tmr_evt, alm_evt} = v[14:12];
            flag_wr    = v[11];
            flag_wdata = {2'b11, v[10:8], 3'b111};
            en_wr      = v[7];
            en_wdata   = v[6:4];
            @(negedge clk);
            idle();
            check({row_tag(i), " flags"}, flag_rdata, {2'b00, v[3:1], 3'b000});
            check({row_tag(i), " irq"}, irq_drive, v[0]);
        end

        // R7 short timer pulse from the 4096 Hz source
        write_en(3'b010);
        tmr_src = 2'd0; tmr_evt = 1;
        @(negedge clk); idle();
        check("R7 timer raises", irq_drive, 1);
        measure(n);
        check("R7 fast timer length", n, 4);

        // R7 long timer pulses for slower sources
        tmr_src = 2'd2; tmr_evt = 1;
        @(negedge clk); idle();
        measure(n);
        check("R7 second-source length", n, 256);
        tmr_src = 2'd3; tmr_evt = 1;
        @(negedge clk); idle();
        measure(n);
        check("R7 minute-source length", n, 256);
        tmr_src = 2'd0;

        // R6 update pulse length and restart
        write_en(3'b100);
        upd_evt = 1;
        @(negedge clk); idle();
        measure(n);
        check("R6 update length", n, UPD_T);
        upd_evt = 1;
        @(negedge clk); idle();
        tick_en = 1;
        repeat (5) @(negedge clk);
        tick_en = 0;
        check("R6 mid-pulse still driven", irq_drive, 1);
        upd_evt = 1;
        @(negedge clk); idle();
        measure(n);
        check("R6 restarted length", n, UPD_T);
        write_flags(8'h00);

        // R4 late enable does not revive an old alarm event
        write_en(3'b000);
        alm_evt = 1;
        @(negedge clk); idle();
        check("R4 alarm flag set", flag_rdata, 8'h08);
        check("R4 no drive", irq_drive, 0);
        write_en(3'b001);
        check("R4 late enable no drive", irq_drive, 0);
        write_flags(8'h00);

        // R8 alarm ignores ticks, R5 OR with update, R10 enable drop
        write_en(3'b101);
        alm_evt = 1;
        @(negedge clk); idle();
        upd_evt = 1;
        @(negedge clk); idle();
        tick_en = 1;
        repeat (300) @(negedge clk);
        tick_en = 0;
        check("R8 alarm held through ticks", irq_drive, 1);
        write_en(3'b100);
        check("R10 alarm enable drop", irq_drive, 0);
        check("R10 flags unchanged", flag_rdata, 8'h28);

        // R1 mid-run reset clears flags and enables
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset clears flags", flag_rdata, 8'h00);
        alm_evt = 1;
        @(negedge clk); idle();
        check("R1 enables off after reset", irq_drive, 0);
        check("R2 flag after reset", flag_rdata, 8'h08);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule